// File: doc/BRIEF.md
# Clock-Generator Control and Status Registers

This block is the software-visible register bank of a clock-generation unit. It sits on an AXI-Lite target port in a single clock domain. Through it, software reads a fixed identifier, a version word, a build stamp and a mask of the clocks that exist. It also reads the lock state of four clock synthesizers, which enter as plain input bits. The bank holds the controls for the reset network that sits beside it: a global reset word, one reset request per output reset domain, and a switch that stops the external main reset from reaching the domain resets.

The global reset is armed only by an exact all-ones value and is released by any other value, including zero. While it is armed, every domain reset request is forced on. The domain request bits pass through to the reset network only while the global reset is released. Reads of offsets that have no register return a recognisable marker word. Writes to those offsets, and to read-only words, change nothing.

Top module: `ckgen_csr`

## Requirements
- R1: After synchronous reset, `glb_rst_o` is 0, `dom_rst_o` is 0x3FE (only domain 0, the main domain, released) and `main_rst_dis_o` is 0.
- R2: Offset 0x00 reads 0x9048_1D0F and offset 0x04 reads 0x0201_0000. Both are read-only.
- R3: Offset 0x08 reads the build stamp {month, day, year, hour}, one byte each with month in bits 31:24. The default is 0x0923_2223. It is read-only.
- R4: Offset 0x0C reads 1 in bits 8:0, one bit per output clock, and 0 in bits 31:9. It is read-only.
- R5: Offset 0x10 stores all 32 written bits and reads them back. `glb_rst_o` is 1 exactly when the stored word is 0xFFFF_FFFF. Any other stored value, including 0x0000_0000, counts as released.
- R6: Offset 0x14 bits 9:0 are read-write and bits 31:10 read 0. Bit n requests reset of domain n. While the global reset is released, `dom_rst_o` equals these bits.
- R7: While the global reset is armed, `dom_rst_o` is all ones, whatever offset 0x14 holds.
- R8: Offset 0x18 bit 0 is read-write and drives `main_rst_dis_o`. Bits 31:1 read 0.
- R9: Offset 0x20 reads the lock inputs at the moment the read is accepted: `lock_i[0]` in bit 0, `lock_i[1]` in bit 4, `lock_i[2]` in bit 6 and `lock_i[3]` in bit 8. All other bits read 0.
- R10: A read of any other offset in the window returns 0xDEAD_DEC0. This includes 0x1C, 0x24 to 0x3C and any offset at or above 0x40. Writes to such offsets, and to offsets 0x00 to 0x0C and 0x20, change no register and no output.
- R11: `s_wstrb` bit k enables byte k (bits 8k+7:8k) of a write. Bytes whose strobe is 0 keep their old value.
- R12: A write is taken in the cycle where `s_awvalid` and `s_wvalid` are both high and no write response is pending. The register and its outputs change in that same edge. `s_bvalid` rises on the next cycle and holds until `s_bready`. A read is taken when `s_arvalid` is high and no read data is pending. `s_rdata` appears with `s_rvalid` on the next cycle and holds until `s_rready`. Both responses are 00 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write byte address within the window |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read byte address within the window |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| lock_i | input | 4 | Synthesizer lock flags |
| glb_rst_o | output | 1 | Global reset armed |
| dom_rst_o | output | 10 | Per-domain reset requests, bit 0 the main domain |
| main_rst_dis_o | output | 1 | Keep external main reset from the domain resets |

## Verification
On every cycle, the assertions check the bus handshake rules: a write response holds until it is taken, and read data stays still until it is taken. They also check that a full-strobe write of all ones or all zeros to the global word arms or releases the global reset on the next cycle. They check that the domain outputs are all ones while the global reset is armed, that a write to the disable word sets the disable output, and that a write outside the three writable words leaves every control output still. Only the bench scenarios can show the values read back: the constants, the lock bit positions, the marker on each unmapped offset and the effect of partial strobes. They also show that a value other than all ones in the global word counts as released and lets the stored domain bits through.

// File: rtl/ckgen_csr_pkg.sv
package ckgen_csr_pkg;

    localparam int DATA_W   = 32;
    localparam int STRB_W   = DATA_W / 8;
    localparam int NUM_DOM  = 10;
    localparam int NUM_CLK  = 9;
    localparam int NUM_LOCK = 4;

    localparam logic [DATA_W-1:0] IDENT_WORD  = 32'h9048_1D0F;
    localparam logic [DATA_W-1:0] REV_WORD    = 32'h0201_0000;
    localparam logic [DATA_W-1:0] HOLE_MARKER = 32'hDEAD_DEC0;

    typedef enum logic [3:0] {
        SL_IDENT,
        SL_REV,
        SL_STAMP,
        SL_AVAIL,
        SL_GLOBAL,
        SL_DOMAIN,
        SL_MDIS,
        SL_LOCK,
        SL_HOLE
    } slot_e;

    typedef struct packed {
        logic [DATA_W-1:0]  glob;
        logic [NUM_DOM-1:0] dom;
        logic               mdis;
    } ctl_s;

    typedef struct packed {
        logic              en;
        logic [31:0]       addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wr_req_s;

    function automatic slot_e decode(input logic [31:0] byte_addr);
        slot_e s;
        if (byte_addr[31:6] != '0) begin
            s = SL_HOLE;
        end else begin
            unique case (byte_addr[5:2])
                4'h0:    s = SL_IDENT;
                4'h1:    s = SL_REV;
                4'h2:    s = SL_STAMP;
                4'h3:    s = SL_AVAIL;
                4'h4:    s = SL_GLOBAL;
                4'h5:    s = SL_DOMAIN;
                4'h6:    s = SL_MDIS;
                4'h8:    s = SL_LOCK;
                default: s = SL_HOLE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] m;
        for (int k = 0; k < STRB_W; k++) begin
            m[8*k +: 8] = {8{strb[k]}};
        end
        return m;
    endfunction

    function automatic int lock_bit(input int idx);
        int p;
        unique case (idx)
            0:       p = 0;
            1:       p = 4;
            2:       p = 6;
            default: p = 8;
        endcase
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] avail_word(input int nclk);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < DATA_W; k++) begin
            if (k < nclk) w[k] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/ckgen_csr_axil.sv
module ckgen_csr_axil
    import ckgen_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [STRB_W-1:0]   s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output wr_req_s             wr_req,
    output logic [31:0]         rd_addr,
    input  logic [DATA_W-1:0]   rd_word
);

    logic              bvalid_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_fire;
    logic              rd_fire;

    assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q;
    assign rd_fire   = s_arvalid & ~rvalid_q;

    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_arready = ~rvalid_q;
    assign s_bvalid  = bvalid_q;
    assign s_rvalid  = rvalid_q;
    assign s_rdata   = rdata_q;
    assign s_bresp   = 2'b00;
    assign s_rresp   = 2'b00;

    assign wr_req.en   = wr_fire;
    assign wr_req.addr = 32'(s_awaddr);
    assign wr_req.data = s_wdata;
    assign wr_req.strb = s_wstrb;
    assign rd_addr     = 32'(s_araddr);

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid_q <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (wr_fire) begin
                bvalid_q <= 1'b1;
            end else if (s_bready) begin
                bvalid_q <= 1'b0;
            end
            if (rd_fire) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_word;
            end else if (s_rready) begin
                rvalid_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ckgen_csr_regs.sv
module ckgen_csr_regs
    import ckgen_csr_pkg::*;
#(
    parameter logic [NUM_DOM-1:0] DOM_INIT = 10'h3FE,
    parameter logic [7:0]         STAMP_MON  = 8'h09,
    parameter logic [7:0]         STAMP_DAY  = 8'h23,
    parameter logic [7:0]         STAMP_YEAR = 8'h22,
    parameter logic [7:0]         STAMP_HOUR = 8'h23
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_req_s             wr_req,
    input  logic [31:0]         rd_addr,
    input  logic [NUM_LOCK-1:0] lock_i,
    output logic [DATA_W-1:0]   rd_word,
    output ctl_s                ctl
);

    localparam logic [DATA_W-1:0] STAMP_WORD = {STAMP_MON, STAMP_DAY, STAMP_YEAR, STAMP_HOUR};
    localparam logic [DATA_W-1:0] AVAIL_WORD = avail_word(NUM_CLK);

    ctl_s              ctl_q;
    ctl_s              ctl_d;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] lock_word;

    assign wmask = byte_mask(wr_req.strb);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_req.en) begin
            unique case (decode(wr_req.addr))
                SL_GLOBAL: ctl_d.glob = (ctl_q.glob & ~wmask) | (wr_req.data & wmask);
                SL_DOMAIN: ctl_d.dom  = (ctl_q.dom & ~wmask[NUM_DOM-1:0])
                                      | (wr_req.data[NUM_DOM-1:0] & wmask[NUM_DOM-1:0]);
                SL_MDIS:   ctl_d.mdis = wmask[0] ? wr_req.data[0] : ctl_q.mdis;
                default:   ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.glob <= '0;
            ctl_q.dom  <= DOM_INIT;
            ctl_q.mdis <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        lock_word = '0;
        for (int i = 0; i < NUM_LOCK; i++) begin
            lock_word[lock_bit(i)] = lock_i[i];
        end
    end

    always_comb begin
        unique case (decode(rd_addr))
            SL_IDENT:  rd_word = IDENT_WORD;
            SL_REV:    rd_word = REV_WORD;
            SL_STAMP:  rd_word = STAMP_WORD;
            SL_AVAIL:  rd_word = AVAIL_WORD;
            SL_GLOBAL: rd_word = ctl_q.glob;
            SL_DOMAIN: rd_word = DATA_W'(ctl_q.dom);
            SL_MDIS:   rd_word = DATA_W'(ctl_q.mdis);
            SL_LOCK:   rd_word = lock_word;
            default:   rd_word = HOLE_MARKER;
        endcase
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/ckgen_csr_rst_map.sv
module ckgen_csr_rst_map
    import ckgen_csr_pkg::*;
(
    input  ctl_s               ctl,
    output logic               glb_rst_o,
    output logic [NUM_DOM-1:0] dom_rst_o,
    output logic               main_rst_dis_o
);

    logic armed;

    assign armed          = &ctl.glob;
    assign glb_rst_o      = armed;
    assign dom_rst_o      = armed ? '1 : ctl.dom;
    assign main_rst_dis_o = ctl.mdis;

endmodule

// File: rtl/ckgen_csr.sv
module ckgen_csr
    import ckgen_csr_pkg::*;
#(
    parameter int                 ADDR_W     = 12,
    parameter logic [NUM_DOM-1:0] DOM_INIT   = 10'h3FE,
    parameter logic [7:0]         STAMP_MON  = 8'h09,
    parameter logic [7:0]         STAMP_DAY  = 8'h23,
    parameter logic [7:0]         STAMP_YEAR = 8'h22,
    parameter logic [7:0]         STAMP_HOUR = 8'h23
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [STRB_W-1:0]   s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    input  logic [NUM_LOCK-1:0] lock_i,
    output logic                glb_rst_o,
    output logic [NUM_DOM-1:0]  dom_rst_o,
    output logic                main_rst_dis_o
);

    wr_req_s           wr_req;
    logic [31:0]       rd_addr;
    logic [DATA_W-1:0] rd_word;
    ctl_s              ctl;

    ckgen_csr_axil #(.ADDR_W(ADDR_W)) i_axil (
        .clk       (clk),
        .rst       (rst),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .wr_req    (wr_req),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word)
    );

    ckgen_csr_regs #(
        .DOM_INIT   (DOM_INIT),
        .STAMP_MON  (STAMP_MON),
        .STAMP_DAY  (STAMP_DAY),
        .STAMP_YEAR (STAMP_YEAR),
        .STAMP_HOUR (STAMP_HOUR)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_addr (rd_addr),
        .lock_i  (lock_i),
        .rd_word (rd_word),
        .ctl     (ctl)
    );

    ckgen_csr_rst_map i_rst_map (
        .ctl            (ctl),
        .glb_rst_o      (glb_rst_o),
        .dom_rst_o      (dom_rst_o),
        .main_rst_dis_o (main_rst_dis_o)
    );

endmodule

// File: rtl/ckgen_csr_chk.sv
module ckgen_csr_chk
    import ckgen_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  s_awaddr,
    input logic               s_awvalid,
    input logic               s_awready,
    input logic [DATA_W-1:0]  s_wdata,
    input logic [STRB_W-1:0]  s_wstrb,
    input logic               s_wvalid,
    input logic               s_wready,
    input logic               s_bvalid,
    input logic               s_bready,
    input logic [DATA_W-1:0]  s_rdata,
    input logic               s_rvalid,
    input logic               s_rready,
    input logic               glb_rst_o,
    input logic [NUM_DOM-1:0] dom_rst_o,
    input logic               main_rst_dis_o
);

    logic              wr_hs;
    logic [ADDR_W-1:0] wr_word;
    logic              to_glob;
    logic              to_mdis;
    logic              to_rw;

    assign wr_hs   = s_awvalid && s_awready && s_wvalid && s_wready;
    assign wr_word = {s_awaddr[ADDR_W-1:2], 2'b00};
    assign to_glob = (wr_word == ADDR_W'(32'h10));
    assign to_mdis = (wr_word == ADDR_W'(32'h18));
    assign to_rw   = to_glob || to_mdis || (wr_word == ADDR_W'(32'h14));

    AST_GLOBAL_ARM: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && to_glob && s_wstrb == '1 && s_wdata == '1) |=> glb_rst_o); // R5

    AST_GLOBAL_FREE: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && to_glob && s_wstrb == '1 && s_wdata == '0) |=> !glb_rst_o); // R5

    AST_ARMED_ALL_DOM: assert property (@(posedge clk) disable iff (rst)
        glb_rst_o |-> (&dom_rst_o)); // R7

    AST_MDIS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && to_mdis && s_wstrb[0]) |=> (main_rst_dis_o == $past(s_wdata[0]))); // R8

    AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && !to_rw) |=> ($stable(glb_rst_o) && $stable(dom_rst_o) && $stable(main_rst_dis_o))); // R10

    AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R12

endmodule

bind ckgen_csr ckgen_csr_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .s_awaddr       (s_awaddr),
    .s_awvalid      (s_awvalid),
    .s_awready      (s_awready),
    .s_wdata        (s_wdata),
    .s_wstrb        (s_wstrb),
    .s_wvalid       (s_wvalid),
    .s_wready       (s_wready),
    .s_bvalid       (s_bvalid),
    .s_bready       (s_bready),
    .s_rdata        (s_rdata),
    .s_rvalid       (s_rvalid),
    .s_rready       (s_rready),
    .glb_rst_o      (glb_rst_o),
    .dom_rst_o      (dom_rst_o),
    .main_rst_dis_o (main_rst_dis_o)
);

// File: tb/test_ckgen_csr.sv
module test_ckgen_csr;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [AW-1:0] s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [AW-1:0] s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic [3:0]  lock_i = '0;
    logic        glb_rst_o;
    logic [9:0]  dom_rst_o;
    logic        main_rst_dis_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_glob;
    logic [9:0]  m_dom;
    logic        m_mdis;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckgen_csr i_ckgen_csr (
        .clk (clk), .rst (rst),
        .s_awaddr (s_awaddr), .s_awvalid (s_awvalid), .s_awready (s_awready),
        .s_wdata (s_wdata), .s_wstrb (s_wstrb), .s_wvalid (s_wvalid), .s_wready (s_wready),
        .s_bresp (s_bresp), .s_bvalid (s_bvalid), .s_bready (s_bready),
        .s_araddr (s_araddr), .s_arvalid (s_arvalid), .s_arready (s_arready),
        .s_rdata (s_rdata), .s_rresp (s_rresp), .s_rvalid (s_rvalid), .s_rready (s_rready),
        .lock_i (lock_i), .glb_rst_o (glb_rst_o), .dom_rst_o (dom_rst_o),
        .main_rst_dis_o (main_rst_dis_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [3:0] lk);
        logic [31:0] r;
        case ({a[AW-1:2], 2'b00})
            12'h000: r = 32'h9048_1D0F;
            12'h004: r = 32'h0201_0000;
            12'h008: r = 32'h0923_2223;
            12'h00C: r = 32'h0000_01FF;
            12'h010: r = m_glob;
            12'h014: r = {22'b0, m_dom};
            12'h018: r = {31'b0, m_mdis};
            12'h020: r = {23'b0, lk[3], 1'b0, lk[2], 1'b0, lk[1], 3'b0, lk[0]};
            default: r = 32'hDEAD_DEC0;
        endcase
        return r;
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] m;
        m = mask_of(s);
        case ({a[AW-1:2], 2'b00})
            12'h010: m_glob = (m_glob & ~m) | (d & m);
            12'h014: m_dom  = (m_dom & ~m[9:0]) | (d[9:0] & m[9:0]);
            12'h018: if (s[0]) m_mdis = d[0];
            default: ;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        logic armed;
        armed = (m_glob == 32'hFFFF_FFFF);
        check(req, {31'b0, glb_rst_o}, {31'b0, armed});
        check(req, {22'b0, dom_rst_o}, {22'b0, armed ? 10'h3FF : m_dom});
        check(req, {31'b0, main_rst_dis_o}, {31'b0, m_mdis});
    endtask

    task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = s;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        model_write(a, d, s);
        check("R12 bvalid", {31'b0, s_bvalid}, 32'd1);
        check("R12 bresp", {30'b0, s_bresp}, 32'd0);
        s_bready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_bready = 1'b0;
        check("R12 bvalid drop", {31'b0, s_bvalid}, 32'd0);
    endtask

    task automatic axi_read(input logic [AW-1:0] a, input bit stall, output logic [31:0] d);
        logic [3:0] lk;
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        lk = lock_i;
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        check("R12 rvalid", {31'b0, s_rvalid}, 32'd1);
        check("R12 rresp", {30'b0, s_rresp}, 32'd0);
        d = s_rdata;
        if (stall) begin
            lock_i = ~lock_i;
            @(negedge clk);
            check("R12 rdata hold", s_rdata, d);
        end
        s_rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_rready = 1'b0;
        check("R9/R10 read data", d, exp_read(a, lk));
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        axi_read(a, 1'b0, d);
        check(req, d, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_glob = '0; m_dom = 10'h3FE; m_mdis = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset defaults
        check("R1 glb", {31'b0, glb_rst_o}, 32'd0);
        check("R1 dom", {22'b0, dom_rst_o}, 32'h3FE);
        check("R1 mdis", {31'b0, main_rst_dis_o}, 32'd0);

        // R2 R3 R4 constants
        read_check("R2 ident", 12'h000, 32'h9048_1D0F);
        read_check("R2 version", 12'h004, 32'h0201_0000);
        read_check("R3 stamp", 12'h008, 32'h0923_2223);
        read_check("R4 avail", 12'h00C, 32'h0000_01FF);
        read_check("R5 glob reset value", 12'h010, 32'h0);
        read_check("R6 dom reset value", 12'h014, 32'h3FE);

        // R2/R10 writes to read-only words change nothing
        axi_write(12'h000, 32'h1234_5678, 4'hF);
        axi_write(12'h00C, 32'h0, 4'hF);
        axi_write(12'h020, 32'hFFFF_FFFF, 4'hF);
        read_check("R2 ident after write", 12'h000, 32'h9048_1D0F);
        read_check("R4 avail after write", 12'h00C, 32'h0000_01FF);
        check_outputs("R10 ro write");

        // R10 holes
        read_check("R10 hole 1C", 12'h01C, 32'hDEAD_DEC0);
        read_check("R10 hole 3C", 12'h03C, 32'hDEAD_DEC0);
        read_check("R10 hole FFC", 12'hFFC, 32'hDEAD_DEC0);
        axi_write(12'h01C, 32'hFFFF_FFFF, 4'hF);
        axi_write(12'h814, 32'h0, 4'hF);
        check_outputs("R10 hole write");
        read_check("R10 dom after hole write", 12'h014, 32'h3FE);

        // R6 domain bits pass while released
        axi_write(12'h014, 32'hFFFF_F155, 4'hF);
        check_outputs("R6 dom pass");
        read_check("R6 dom readback", 12'h014, 32'h155);

        // R5 R7 exact all-ones arms
        axi_write(12'h010, 32'hFFFF_FFFF, 4'hF);
        check_outputs("R7 armed");
        axi_write(12'h014, 32'h0, 4'hF);
        check_outputs("R7 armed dom ignored");
        axi_write(12'h010, 32'hFFFF_FFFE, 4'hF);
        check_outputs("R5 near ones released");
        read_check("R5 glob stored", 12'h010, 32'hFFFF_FFFE);
        axi_write(12'h010, 32'hFFFF_FFFF, 4'h1);
        check_outputs("R11 strobe completes ones");
        axi_write(12'h010, 32'h0, 4'hF);
        check_outputs("R5 zero releases");

        // R8 disable bit
        axi_write(12'h018, 32'hFFFF_FFFF, 4'hF);
        check_outputs("R8 mdis set");
        read_check("R8 mdis readback", 12'h018, 32'h1);
        axi_write(12'h018, 32'h0, 4'hE);
        check_outputs("R11 mdis masked");

        // R11 partial strobe on domain word
        axi_write(12'h014, 32'h0000_0300, 4'h2);
        read_check("R11 dom upper byte", 12'h014, {22'b0, m_dom});

        // R9 lock positions
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            lock_i = 4'(1 << k);
            axi_read(12'h020, 1'b0, d);
        end
        @(negedge clk);
        lock_i = 4'hA;
        axi_read(12'h020, 1'b1, d);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [AW-1:0] a;
            logic [31:0]   dat;
            logic [3:0]    st;
            int            pick;
            pick = int'($urandom_range(0, 11));
            case (pick)
                9:       a = 12'h01C;
                10:      a = AW'(12'h040 + 4 * $urandom_range(0, 1000));
                11:      a = 12'h024;
                default: a = AW'(4 * (pick < 8 ? pick : 8));
            endcase
            case ($urandom_range(0, 3))
                0:       dat = 32'hFFFF_FFFF;
                1:       dat = 32'h0;
                default: dat = $urandom;
            endcase
            st = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
            @(negedge clk);
            lock_i = 4'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                axi_write(a, dat, st);
                check_outputs("R5/R6/R7/R8/R11 random");
            end else begin
                axi_read(a, ($urandom_range(0, 4) == 0), d);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule